// File: doc/BRIEF.md
# Floating-Point Data Class Tester

This block looks at a binary floating-point operand in either single (32-bit) or double (64-bit) format and sorts it into one of six categories: zero, normal, subnormal, infinity, quiet NaN or signaling NaN. Each category has a positive and a negative variant. The category and the sign pick one bit of a 12-bit class-select mask. The block then reports whether that bit is set. The one-bit answer is meant to be used as a condition code by the surrounding execution logic.

A single-precision operand sits in the low 32 bits of the operand bus, and the upper bits are then ignored. The match bit is available combinationally on `comb_hit`. A registered copy is also provided. It sits behind a one-stage valid/ready handshake: an accepted request appears on `out_hit` with `out_valid` one cycle later, and it is held there until the consumer takes it.

Top module: `fpdc_tester`

## Requirements
- R1: An operand with a zero exponent and a zero fraction is a zero, at position 0.
- R2: An operand whose exponent is neither all zeros nor all ones is normal, at position 2.
- R3: An operand with a zero exponent and a non-zero fraction is subnormal, at position 4.
- R4: An operand with an all-ones exponent and a zero fraction is an infinity, at position 6.
- R5: An operand with an all-ones exponent and a non-zero fraction is a NaN. It is quiet, at position 8, when the top fraction bit is 1. It is signaling, at position 10, when that bit is 0.
- R6: For every category, including NaNs, the sign bit chooses the mask bit. For position p, a positive operand selects `in_mask[11-p]` and a negative operand selects `in_mask[10-p]`. For example, +0 selects `in_mask[11]` and a negative signaling NaN selects `in_mask[0]`.
- R7: When `in_wide`=0, the operand is taken from `in_operand[31:0]`, with the sign at bit 31, an 8-bit exponent and a 23-bit fraction, and bits 63:32 have no effect. When `in_wide`=1, the full 64 bits are used, with the sign at bit 63, an 11-bit exponent and a 52-bit fraction.
- R8: `comb_hit` is 1 exactly when the selected mask bit is 1. An all-zero mask always gives 0, and an all-ones mask always gives 1.
- R9: When `in_valid` and `in_ready` are both high at a clock edge, `out_valid` is high after that edge and `out_hit` equals the match bit of the accepted request. These stay unchanged while `out_ready` is low, and every accepted request is delivered exactly once.
- R10: `in_ready` is high when `out_valid` is low or `out_ready` is high.
- R11: During and after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_operand | input | 64 | Operand bits; single format uses bits 31:0 |
| in_wide | input | 1 | 1 = double format, 0 = single format |
| in_mask | input | 12 | Class-select mask |
| comb_hit | output | 1 | Combinational match bit |
| out_valid | output | 1 | Registered result present |
| out_ready | input | 1 | Consumer takes the result |
| out_hit | output | 1 | Registered match bit |

## Verification
A wrong category or a wrong sign decode shows up on `comb_hit` in the same cycle, but only for masks that separate the correct bit from the one actually chosen. For that reason every test operand is swept through all twelve one-hot masks, and also through the all-zero and all-ones masks. A fault in the output stage shows up one cycle after acceptance. It appears either as a dropped, duplicated or altered result in the scoreboard queue, or as `out_hit` changing while the consumer stalls. The stall pattern on `out_ready` drives both the hold path and the back-pressure on `in_ready`.

// File: rtl/fpdc_pkg.sv
package fpdc_pkg;

    // Category code; times two gives the mask position
    typedef enum logic [2:0] {
        CAT_ZERO = 3'd0,
        CAT_NORM = 3'd1,
        CAT_SUB  = 3'd2,
        CAT_INF  = 3'd3,
        CAT_QNAN = 3'd4,
        CAT_SNAN = 3'd5
    } fp_cat_e;

    typedef struct packed {
        logic sign;
        logic exp_ones;
        logic exp_zero;
        logic frac_zero;
        logic frac_top;
    } fp_fields_t;

    typedef struct packed {
        fp_cat_e cat;
        logic    neg;
    } fp_kind_t;

    typedef struct packed {
        logic vld;
        logic hit;
    } out_stage_t;

endpackage

// File: rtl/fpdc_field_decode.sv
module fpdc_field_decode
    import fpdc_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] bits_i,
    output fp_fields_t            fields_o
);
    localparam int SIGN_POS = EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_field;
    logic [FRAC_W-1:0] frac_field;

    always_comb begin
        exp_field          = bits_i[SIGN_POS-1:FRAC_W];
        frac_field         = bits_i[FRAC_W-1:0];
        fields_o.sign      = bits_i[SIGN_POS];
        fields_o.exp_ones  = &exp_field;
        fields_o.exp_zero  = ~|exp_field;
        fields_o.frac_zero = ~|frac_field;
        fields_o.frac_top  = frac_field[FRAC_W-1];
    end
endmodule

// File: rtl/fpdc_classify.sv
module fpdc_classify
    import fpdc_pkg::*;
(
    input  fp_fields_t fields_i,
    output fp_kind_t   kind_o
);
    always_comb begin
        kind_o.neg = fields_i.sign;
        if (!fields_i.exp_zero && !fields_i.exp_ones) begin
            kind_o.cat = CAT_NORM;
        end else if (fields_i.exp_zero && fields_i.frac_zero) begin
            kind_o.cat = CAT_ZERO;
        end else if (fields_i.exp_zero) begin
            kind_o.cat = CAT_SUB;
        end else if (fields_i.frac_zero) begin
            kind_o.cat = CAT_INF;
        end else if (fields_i.frac_top) begin
            kind_o.cat = CAT_QNAN;
        end else begin
            kind_o.cat = CAT_SNAN;
        end
    end
endmodule

// File: rtl/fpdc_mask_test.sv
module fpdc_mask_test
    import fpdc_pkg::*;
#(
    parameter int MASK_W = 12
) (
    input  fp_kind_t          kind_i,
    input  logic [MASK_W-1:0] mask_i,
    output logic              hit_o
);
    localparam int TOP = MASK_W - 1;

    logic [MASK_W-1:0] sel;

    // Position p (= 2*category) maps to index TOP-p, or TOP-p-1 if negative
    always_comb begin
        for (int k = 0; k < MASK_W; k++) begin
            sel[k] = (k == (TOP - 2 * int'(kind_i.cat) - int'(kind_i.neg)));
        end
        hit_o = |(sel & mask_i);
    end
endmodule

// File: rtl/fpdc_tester.sv
module fpdc_tester
    import fpdc_pkg::*;
#(
    parameter int SP_EXP_W  = 8,
    parameter int SP_FRAC_W = 23,
    parameter int DP_EXP_W  = 11,
    parameter int DP_FRAC_W = 52,
    parameter int MASK_W    = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [DP_EXP_W+DP_FRAC_W:0] in_operand,
    input  logic                in_wide,
    input  logic [MASK_W-1:0]   in_mask,
    output logic                comb_hit,
    output logic                out_valid,
    input  logic                out_ready,
    output logic                out_hit
);
    localparam int SP_W = 1 + SP_EXP_W + SP_FRAC_W;
    localparam int DP_W = 1 + DP_EXP_W + DP_FRAC_W;

    fp_fields_t fmt_fields [2];
    fp_fields_t fields_sel;
    fp_kind_t   kind;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_fmt
            if (g == 0) begin : g_single
                fpdc_field_decode #(.EXP_W(SP_EXP_W), .FRAC_W(SP_FRAC_W)) u_dec (
                    .bits_i  (in_operand[SP_W-1:0]),
                    .fields_o(fmt_fields[g])
                );
            end else begin : g_double
                fpdc_field_decode #(.EXP_W(DP_EXP_W), .FRAC_W(DP_FRAC_W)) u_dec (
                    .bits_i  (in_operand[DP_W-1:0]),
                    .fields_o(fmt_fields[g])
                );
            end
        end
    endgenerate

    assign fields_sel = in_wide ? fmt_fields[1] : fmt_fields[0];

    fpdc_classify u_cls (
        .fields_i(fields_sel),
        .kind_o  (kind)
    );

    fpdc_mask_test #(.MASK_W(MASK_W)) u_msk (
        .kind_i(kind),
        .mask_i(in_mask),
        .hit_o (comb_hit)
    );

    out_stage_t st_d, st_q;
    logic       take_in;

    always_comb begin
        st_d     = st_q;
        in_ready = !st_q.vld || out_ready;
        take_in  = in_valid && in_ready;
        if (take_in) begin
            st_d.vld = 1'b1;
            st_d.hit = comb_hit;
        end else if (out_ready) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_hit   = st_q.hit;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_hit)); // R9
    AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid); // R9
    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_hit == $past(comb_hit)); // R9
    AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !in_valid |=> !out_valid); // R9
    AST_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R10
    AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        in_mask == '0 |-> !comb_hit); // R8
    AST_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        &in_mask |-> comb_hit); // R8
endmodule

// File: tb/fpdc_tester_test.sv
module fpdc_tester_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_operand = '0;
    logic        in_wide = 1'b0;
    logic [11:0] in_mask = '0;
    logic        comb_hit;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        out_hit;

    always #4 clk = ~clk;

    fpdc_tester uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_operand(in_operand), .in_wide(in_wide), .in_mask(in_mask),
        .comb_hit(comb_hit), .out_valid(out_valid), .out_ready(out_ready),
        .out_hit(out_hit)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    exp_q[$];
    string tag_q[$];
    bit    stall_on = 1'b0;
    int    cyc = 0;
    bit    finished = 1'b0;

    task automatic check(input bit act, input bit exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // Independent model of the requirements R1..R7
    function automatic int model_pos(input logic [63:0] op, input bit wide,
                                     output bit neg, output string tag);
        logic [10:0] e;
        logic [51:0] f;
        bit e1, e0, fz, ft;
        int p;
        if (wide) begin
            neg = op[63]; e = op[62:52]; f = op[51:0];
            e1 = (e == 11'h7FF); e0 = (e == 0); fz = (f == 0); ft = f[51];
        end else begin
            neg = op[31]; e = {3'b0, op[30:23]}; f = {29'b0, op[22:0]};
            e1 = (op[30:23] == 8'hFF); e0 = (op[30:23] == 0);
            fz = (op[22:0] == 0); ft = op[22];
        end
        if (e0 && fz)      begin p = 0;  tag = "R1"; end
        else if (e0)       begin p = 4;  tag = "R3"; end
        else if (!e1)      begin p = 2;  tag = "R2"; end
        else if (fz)       begin p = 6;  tag = "R4"; end
        else if (ft)       begin p = 8;  tag = "R5"; end
        else               begin p = 10; tag = "R5"; end
        return p;
    endfunction

    task automatic send(input logic [63:0] op, input bit wide,
                        input logic [11:0] m, input string extra);
        bit    neg;
        string tag;
        int    p;
        bit    e;
        p = model_pos(op, wide, neg, tag);
        e = m[11 - p - int'(neg)];
        if (neg) tag = {tag, "/R6"};
        tag = {tag, extra, "/R8"};
        in_operand = op; in_wide = wide; in_mask = m; in_valid = 1'b1;
        #1;
        check(comb_hit, e, tag);
        while (!in_ready) begin
            @(negedge clk); #1;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    // Consumer back-pressure, changed away from both edges
    always @(posedge clk) begin
        #1;
        cyc++;
        out_ready = stall_on ? (cyc % 3 == 0) : 1'b1;
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            check(in_ready, !out_valid || out_ready, "R10");
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R9: actual unexpected result %0b expected none", out_hit);
                end else begin
                    string t;
                    bit    e;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(out_hit, e, {"R9 ", t});
                end
            end
        end
    end

    initial begin
        logic [63:0] ops [24];
        bit          wd  [24];
        string       ex  [24];
        ops[0]  = 64'h0000_0000; wd[0]  = 0; ex[0]  = "";
        ops[1]  = 64'h8000_0000; wd[1]  = 0; ex[1]  = "";
        ops[2]  = 64'h3F80_0000; wd[2]  = 0; ex[2]  = "";
        ops[3]  = 64'hC000_0000; wd[3]  = 0; ex[3]  = "";
        ops[4]  = 64'h0000_0001; wd[4]  = 0; ex[4]  = "";
        ops[5]  = 64'h807F_FFFF; wd[5]  = 0; ex[5]  = "";
        ops[6]  = 64'h7F80_0000; wd[6]  = 0; ex[6]  = "";
        ops[7]  = 64'hFF80_0000; wd[7]  = 0; ex[7]  = "";
        ops[8]  = 64'h7FC0_0000; wd[8]  = 0; ex[8]  = "";
        ops[9]  = 64'hFFC0_0001; wd[9]  = 0; ex[9]  = "";
        ops[10] = 64'h7F80_0001; wd[10] = 0; ex[10] = "";
        ops[11] = 64'hFFBF_FFFF; wd[11] = 0; ex[11] = "";
        ops[12] = 64'hFFFF_FFFF_3F80_0000; wd[12] = 0; ex[12] = "/R7";
        ops[13] = 64'h7FF0_0000_0000_0000; wd[13] = 0; ex[13] = "/R7";
        ops[14] = 64'h0000_0000_7F80_0000; wd[14] = 1; ex[14] = "/R7";
        ops[15] = 64'h3FF0_0000_0000_0000; wd[15] = 1; ex[15] = "/R7";
        ops[16] = 64'h8000_0000_0000_0000; wd[16] = 1; ex[16] = "/R7";
        ops[17] = 64'h0000_0000_0000_0001; wd[17] = 1; ex[17] = "/R7";
        ops[18] = 64'hFFF0_0000_0000_0000; wd[18] = 1; ex[18] = "/R7";
        ops[19] = 64'h7FF8_0000_0000_0000; wd[19] = 1; ex[19] = "/R7";
        ops[20] = 64'hFFF8_0000_0000_0001; wd[20] = 1; ex[20] = "/R7";
        ops[21] = 64'h7FF0_0000_0000_0001; wd[21] = 1; ex[21] = "/R7";
        ops[22] = 64'hFFF7_FFFF_FFFF_FFFF; wd[22] = 1; ex[22] = "/R7";
        ops[23] = 64'h800F_FFFF_FFFF_FFFF; wd[23] = 1; ex[23] = "/R7";

        repeat (3) @(negedge clk);
        check(out_valid, 1'b0, "R11 out_valid in reset");
        check(in_ready, 1'b1, "R11 in_ready in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid, 1'b0, "R11 out_valid after reset");

        for (int pass = 0; pass < 2; pass++) begin
            stall_on = (pass == 1);
            for (int i = 0; i < 24; i++) begin
                for (int m = 0; m < 14; m++) begin
                    logic [11:0] mk;
                    mk = (m < 12) ? (12'h001 << m) : ((m == 12) ? 12'h000 : 12'hFFF);
                    send(ops[i], wd[i], mk, ex[i]);
                end
            end
        end
        in_valid = 1'b0;
        stall_on = 1'b0;
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, 1'b1, "R9 all results delivered");
        check(out_valid, 1'b0, "R9 idle after drain");
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule